// File: doc/BRIEF.md
# Nibble-Bus Memory Read Responder

This block sits on the peripheral side of a four-bit multiplexed low-pin-count bus and answers memory read cycles. It watches the active-low frame strobe and the nibble bus, recognises the start of a cycle, and checks the cycle-type code. It then collects a 32-bit address sent as eight nibbles, highest nibble first.

Once the host has turned the bus around, the block drives a ready code. It returns one byte fetched through a synchronous memory read port, low nibble first. It finishes by driving all ones for one clock and then releases the bus. The shared data lines appear as separate input, output and output-enable signals. All bus outputs change on the falling clock edge, and the host samples them on the rising edge.

Top module: `lpc_rd_target`

## Requirements
- R1: While reset is asserted and right after it, `lad_oe` and `mem_rd` are low.
- R2: A cycle starts only on a rising edge where `frame_n` is low and `lad_in` is 4'h0. A low `frame_n` with any other nibble starts nothing.
- R3: The nibble that follows the start is the cycle type. Only the values 4'h4 and 4'h5 (bits 3:1 equal 3'b010) are memory reads. Any other value returns the block to idle without driving the bus and without a memory request.
- R4: The next eight nibbles form the address, most significant first. On the clock after the last address nibble, `mem_rd` is high for exactly one clock and `mem_addr` holds the assembled address.
- R5: During the two turnaround clocks after the address, `lad_oe` is low. On the third clock after the last address nibble, the block drives 4'h0 (ready).
- R6: Read data arrives on `mem_data` one clock after `mem_rd`. The block drives bits 3:0 of that byte on the clock after the ready code, and bits 7:4 on the clock after that.
- R7: After the data, the block drives 4'hF for one clock and then lowers `lad_oe`. `lad_oe` is high only during the ready, two data and final clocks.
- R8: A low `frame_n` on any rising edge aborts a cycle in progress. `lad_oe` is low from the next clock, and decoding restarts at the start check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; inputs sampled on rising edge, outputs changed on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble bus as seen by the block |
| lad_out | output | 4 | Nibble the block drives when enabled |
| lad_oe | output | 1 | High while the block drives the nibble bus |
| mem_rd | output | 1 | One-clock memory read request |
| mem_addr | output | 32 | Assembled read address, valid with `mem_rd` |
| mem_data | input | 8 | Byte from memory, valid one clock after `mem_rd` |

## Verification
The assertions check the following on every cycle:
- the one-clock memory request after the last address nibble;
- quiet bus during turnaround;
- the ready code and the low data nibble at their fixed offsets from the request;
- silence after a rejected cycle type or after any low frame strobe.

Only the bench scenarios show the rest. These are the full sweep of all sixteen cycle-type codes, the high data nibble, and the final all-ones clock followed by release. They also cover a start ignored for a wrong nibble and an abort in the middle of data. The bench checks these against an address-to-byte rule it computes itself.

// File: rtl/lpc_rd_pkg.sv
package lpc_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTYPE,
    ST_ADDR,
    ST_TURN0,
    ST_TURN1,
    ST_READY,
    ST_DLOW,
    ST_DHIGH,
    ST_FINAL
  } lrt_state_e;

  localparam logic [3:0] NIB_START = 4'h0;
  localparam logic [3:0] NIB_READY = 4'h0;
  localparam logic [3:0] NIB_ONES  = 4'hF;

  function automatic logic is_mem_read(input logic [3:0] code);
    return code[3:1] == 3'b010;
  endfunction

  function automatic logic drives_bus(input lrt_state_e s);
    return (s == ST_READY) || (s == ST_DLOW) || (s == ST_DHIGH) || (s == ST_FINAL);
  endfunction

  function automatic logic [3:0] tx_nibble(input lrt_state_e s, input logic [7:0] d);
    logic [3:0] n;
    case (s)
      ST_READY: n = NIB_READY;
      ST_DLOW:  n = d[3:0];
      ST_DHIGH: n = d[7:4];
      default:  n = NIB_ONES;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/lpc_rd_decode.sv
module lpc_rd_decode
  import lpc_rd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  input  logic [7:0]        mem_data,
  output lrt_state_e        state,
  output logic [ADDR_W-1:0] addr_q,
  output logic [7:0]        data_q,
  output logic              ev_start,
  output logic              ev_ctype_bad,
  output logic              ev_addr_done
);
  localparam int NIBS  = ADDR_W / 4;
  localparam int CNT_W = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam logic [CNT_W-1:0] LAST_NIB = CNT_W'(NIBS - 1);

  lrt_state_e       nxt;
  logic [CNT_W-1:0] nib_cnt;

  assign ev_start     = !frame_n && (lad_in == NIB_START);
  assign ev_ctype_bad = frame_n && (state == ST_CTYPE) && !is_mem_read(lad_in);
  assign ev_addr_done = frame_n && (state == ST_ADDR) && (nib_cnt == LAST_NIB);

  always_comb begin
    nxt = ST_IDLE;
    if (!frame_n) begin
      nxt = ev_start ? ST_CTYPE : ST_IDLE;
    end else begin
      case (state)
        ST_CTYPE: nxt = is_mem_read(lad_in) ? ST_ADDR : ST_IDLE;
        ST_ADDR:  nxt = ev_addr_done ? ST_TURN0 : ST_ADDR;
        ST_TURN0: nxt = ST_TURN1;
        ST_TURN1: nxt = ST_READY;
        ST_READY: nxt = ST_DLOW;
        ST_DLOW:  nxt = ST_DHIGH;
        ST_DHIGH: nxt = ST_FINAL;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      nib_cnt <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state <= nxt;
      if (state != ST_ADDR) begin
        nib_cnt <= '0;
      end else if (frame_n) begin
        nib_cnt <= nib_cnt + 1'b1;
        addr_q  <= {addr_q[ADDR_W-5:0], lad_in};
      end
      if (state == ST_TURN1) begin
        data_q <= mem_data;
      end
    end
  end

endmodule

// File: rtl/lpc_rd_drive.sv
module lpc_rd_drive
  import lpc_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lrt_state_e state,
  input  logic [7:0] data_q,
  output logic [3:0] lad_out,
  output logic       lad_oe
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lad_oe  <= 1'b0;
      lad_out <= NIB_ONES;
    end else begin
      lad_oe  <= drives_bus(state);
      lad_out <= tx_nibble(state, data_q);
    end
  end

endmodule

// File: rtl/lpc_rd_target.sv
module lpc_rd_target
  import lpc_rd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data
);
  lrt_state_e state;
  logic [7:0] data_q;
  logic       ev_start;
  logic       ev_ctype_bad;
  logic       ev_addr_done;

  lpc_rd_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_n      (frame_n),
    .lad_in       (lad_in),
    .mem_data     (mem_data),
    .state        (state),
    .addr_q       (mem_addr),
    .data_q       (data_q),
    .ev_start     (ev_start),
    .ev_ctype_bad (ev_ctype_bad),
    .ev_addr_done (ev_addr_done)
  );

  lpc_rd_drive u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .data_q  (data_q),
    .lad_out (lad_out),
    .lad_oe  (lad_oe)
  );

  assign mem_rd = (state == ST_TURN0);

endmodule

// File: rtl/lpc_rd_target_chk.sv
module lpc_rd_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic [3:0] lad_out,
  input logic       lad_oe,
  input logic       mem_rd,
  input logic [7:0] mem_data,
  input logic       ev_ctype_bad,
  input logic       ev_addr_done
);
  // R4
  req_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_done |=> mem_rd);

  // R4
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R5
  turn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !lad_oe);

  // R5
  ready_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_rd, 2) && $past(frame_n, 2) && $past(frame_n, 1)) |-> (lad_oe && lad_out == 4'h0));

  // R6
  low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_rd, 3) && $past(frame_n, 3) && $past(frame_n, 2) && $past(frame_n, 1))
      |-> (lad_oe && lad_out == $past(mem_data[3:0], 2)));

  // R3
  bad_type_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ctype_bad |=> (!lad_oe && !mem_rd));

  // R8
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !lad_oe);

endmodule

bind lpc_rd_target lpc_rd_target_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_n      (frame_n),
  .lad_out      (lad_out),
  .lad_oe       (lad_oe),
  .mem_rd       (mem_rd),
  .mem_data     (mem_data),
  .ev_ctype_bad (ev_ctype_bad),
  .ev_addr_done (ev_addr_done)
);

// File: tb/test_lpc_rd_target.sv
`timescale 1ns/1ps
module test_lpc_rd_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic [7:0]  mem_data = 8'h00;

  int n_checks = 0;
  int n_fails  = 0;
  logic        s_oe, s_rd;
  logic [3:0]  s_out;
  logic [31:0] s_addr;

  always #2.5 clk = ~clk;

  lpc_rd_target i_lpc_rd_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  function automatic logic [7:0] byte_of(input logic [31:0] a);
    return a[7:0] ^ a[31:24] ^ {a[19:16], a[11:8]} ^ 8'hA5;
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= byte_of(mem_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one bus clock: host drives at the falling edge, sample just before the rising edge
  task automatic slot(input logic fr, input logic [3:0] nib);
    @(negedge clk);
    frame_n = fr;
    lad_in  = nib;
    #2;
    s_oe = lad_oe; s_out = lad_out; s_rd = mem_rd; s_addr = mem_addr;
  endtask

  task automatic idle_slots(input int n);
    for (int i = 0; i < n; i++) slot(1'b1, 4'hF);
  endtask

  task automatic do_read(input logic [3:0] ctype, input logic [31:0] a);
    bit ok_type;
    logic [7:0] b;
    ok_type = (ctype == 4'h4) || (ctype == 4'h5);
    b = byte_of(a);
    slot(1'b0, 4'h0);
    check(!s_oe, "R2", {31'd0, s_oe}, 0);
    slot(1'b1, ctype);
    for (int k = 7; k >= 0; k--) begin
      slot(1'b1, a[4*k +: 4]);
      check(!s_oe && !s_rd, "R3", {s_oe, s_rd}, 0);
    end
    slot(1'b1, 4'hF);
    if (ok_type) begin
      check(s_rd && s_addr == a, "R4", s_addr, a);
      check(!s_oe, "R5", {31'd0, s_oe}, 0);
    end else begin
      check(!s_rd && !s_oe, "R3", {s_oe, s_rd}, 0);
    end
    slot(1'b1, 4'hF);
    check(!s_oe && !s_rd, ok_type ? "R5" : "R3", {s_oe, s_rd}, 0);
    slot(1'b1, 4'hF);
    if (ok_type) check(s_oe && s_out == 4'h0, "R5", {s_oe, s_out}, {1'b1, 4'h0});
    else check(!s_oe, "R3", {31'd0, s_oe}, 0);
    slot(1'b1, 4'hF);
    if (ok_type) check(s_oe && s_out == b[3:0], "R6", {s_oe, s_out}, {1'b1, b[3:0]});
    else check(!s_oe, "R3", {31'd0, s_oe}, 0);
    slot(1'b1, 4'hF);
    if (ok_type) check(s_oe && s_out == b[7:4], "R6", {s_oe, s_out}, {1'b1, b[7:4]});
    else check(!s_oe, "R3", {31'd0, s_oe}, 0);
    slot(1'b1, 4'hF);
    if (ok_type) check(s_oe && s_out == 4'hF, "R7", {s_oe, s_out}, {1'b1, 4'hF});
    else check(!s_oe, "R3", {31'd0, s_oe}, 0);
    slot(1'b1, 4'hF);
    check(!s_oe && !s_rd, "R7", {s_oe, s_rd}, 0);
  endtask

  initial begin
    s_oe = 1'b0; s_rd = 1'b0; s_out = 4'h0; s_addr = '0;
    #1;
    check(!lad_oe && !mem_rd, "R1", {lad_oe, mem_rd}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle_slots(2);
    check(!s_oe && !s_rd, "R1", {s_oe, s_rd}, 0);

    // R3: every cycle-type code
    for (int t = 0; t < 16; t++) do_read(4'(t), 32'hFFFF_FFFF - 32'(t));

    // R4 R6: address and data sweep
    for (int i = 0; i < 256; i++) do_read(4'h4, (32'(i) * 32'h0101_0001) ^ 32'h3C00_5A00 ^ (32'(i) << 12));

    // R2: low strobe with a non-zero nibble starts nothing
    slot(1'b0, 4'h3);
    slot(1'b1, 4'h4);
    for (int k = 0; k < 8; k++) slot(1'b1, 4'h1);
    slot(1'b1, 4'hF);
    check(!s_rd, "R2", {31'd0, s_rd}, 0);
    for (int k = 0; k < 6; k++) begin
      slot(1'b1, 4'hF);
      check(!s_oe, "R2", {31'd0, s_oe}, 0);
    end

    // R8: abort during the low data nibble, then a clean read follows
    slot(1'b0, 4'h0);
    slot(1'b1, 4'h4);
    for (int k = 0; k < 8; k++) slot(1'b1, 4'(k + 1));
    slot(1'b1, 4'hF);
    slot(1'b1, 4'hF);
    slot(1'b1, 4'hF);
    slot(1'b0, 4'h7);
    check(s_oe, "R8", {31'd0, s_oe}, 1);
    slot(1'b1, 4'hF);
    check(!s_oe, "R8", {31'd0, s_oe}, 0);
    idle_slots(3);
    check(!s_oe, "R8", {31'd0, s_oe}, 0);
    do_read(4'h5, 32'h1234_5678);

    idle_slots(2);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule